// File: doc/BRIEF.md
# Segment Load and Translation Unit

This unit holds six segment registers for protected-mode address formation. A load request names a register and supplies a 16-bit selector. The unit splits the selector into its fields and picks the global or the local descriptor table. It checks that the whole 8-byte entry lies inside that table's byte limit. It then fetches the entry as two 32-bit reads. The descriptor is decoded and checked, and its base, effective limit and attribute bits go into a hidden cache entry kept for each register.

A translate request names a register and gives a 32-bit offset. The unit checks the offset against the cached effective limit and returns the linear address, which is the cached base plus the offset, together with the cached attributes and the requested privilege level. The descriptor table is not read again. Only one load is in flight at a time. Translation runs on its own path, and it sees a new cache entry from the cycle in which the load that wrote it reports completion.

All faults share one 2-bit cause code: `00` none, `01` general protection, `10` segment not present, `11` register number out of range. Segment registers are numbered 0 to 5, and number 2 is the stack register.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `busy_o`, `mem_req_o`, `ld_done_o`, `ld_fault_o` and `xl_valid_o` are 0 and all six cache entries are empty. A translate of an empty register faults with cause `10`.
- R2: Selector bits [15:3] are the table index, bit 2 picks the table (0 global, 1 local) and bits [1:0] are the requested privilege level. A later translate of the register returns those two bits on `xl_rpl_o`.
- R3: If index*8+7 is above the chosen table's 16-bit byte limit, the load faults with cause `01` in the cycle after the request. No memory read is issued and the register keeps its old contents.
- R4: An accepted load reads the low word at table base + index*8 and then the high word at that address + 4. `mem_req_o` and `mem_addr_o` stay unchanged until a cycle with `mem_rvalid_i` high, and `mem_rdata_i` is taken in that cycle.
- R5: Descriptor layout. Low word: limit[15:0] in [15:0], base[15:0] in [31:16]. High word: base[23:16] in [7:0], type in [11:8], system flag S in [12], privilege in [14:13], present P in [15], limit[19:16] in [19:16], AVL in [20], L in [21], default size in [22], granularity G in [23], base[31:24] in [31:24]. `xl_attr_o` returns {G, size, L, AVL, P, privilege[1:0], S, type[3:0]} in bits 11..0.
- R6: With G=0 the effective limit is the 20-bit limit. With G=1 it is the limit shifted left by 12 with the low 12 bits set to ones.
- R7: A descriptor with P=0 faults with cause `10` and leaves the register unchanged.
- R8: A load of register 2 faults with cause `01` unless S=1, type bit 3 is 0 and type bit 1 is 1 (a writable data segment). This check takes precedence over the present check. Other registers accept any type.
- R9: `ld_done_o` or `ld_fault_o` pulses for one cycle, in the cycle after the edge that takes the second read word. A translate requested in that cycle already sees the new entry.
- R10: `busy_o` is high from the cycle after a load is accepted until the cycle its result is signalled. A load request that arrives while busy is ignored.
- R11: A translate gives `xl_valid_o` one cycle later. Without a fault, `lin_addr_o` is base + offset modulo 2^32. When `xl_valid_o` is low, or the translate faults, `lin_addr_o`, `xl_attr_o` and `xl_rpl_o` are 0.
- R12: A translate offset above the effective limit faults with cause `01`. An offset equal to the limit passes.
- R13: A register number of 6 or 7 faults with cause `11`, on a load in the next cycle and on a translate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gtab_base_i | input | 32 | Global table linear base |
| gtab_lim_i | input | 16 | Global table byte limit |
| ltab_base_i | input | 32 | Local table linear base |
| ltab_lim_i | input | 16 | Local table byte limit |
| ld_req_i | input | 1 | Load request |
| ld_sreg_i | input | 3 | Register number to load |
| ld_sel_i | input | 16 | Selector to load |
| busy_o | output | 1 | Load in progress |
| ld_done_o | output | 1 | Load completed, one-cycle pulse |
| ld_fault_o | output | 1 | Load faulted, one-cycle pulse |
| ld_cause_o | output | 2 | Load fault cause |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| xl_req_i | input | 1 | Translate request |
| xl_sreg_i | input | 3 | Register number to translate through |
| xl_off_i | input | 32 | Offset |
| xl_valid_o | output | 1 | Translate result valid |
| xl_fault_o | output | 1 | Translate faulted |
| xl_cause_o | output | 2 | Translate fault cause |
| lin_addr_o | output | 32 | Linear address |
| xl_attr_o | output | 12 | Cached attribute bits |
| xl_rpl_o | output | 2 | Cached requested privilege level |

## Verification
A corrupt cache entry only becomes visible when that register is next translated. It then shows up in the same result cycle as a wrong `lin_addr_o`, a wrong attribute or a wrong fault code, so the bench translates every register right after each load and keeps translating during loads. A wrong table choice or a wrong index scaling shows on `mem_addr_o` in the first cycle of the fetch. A wrong field split shows as a wrong limit fault in the cycle after the request. A lost or extra phase in the load sequencer shows up at once on `busy_o`, on the second read address, or on a completion pulse one cycle early or late.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned AW    = 32;
  localparam int unsigned SEL_W = 16;
  localparam int unsigned TLM_W = 16;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_GP   = 2'b01,
    CAUSE_NP   = 2'b10,
    CAUSE_REG  = 2'b11
  } cause_e;

  typedef struct packed {
    logic       g;
    logic       db;
    logic       lng;
    logic       avl;
    logic       p;
    logic [1:0] dpl;
    logic       s;
    logic [3:0] typ;
  } attr_t;

  typedef struct packed {
    logic          vld;
    logic [AW-1:0] base;
    logic [AW-1:0] lim;
    attr_t         attr;
    logic [1:0]    rpl;
  } cache_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [AW-1:0]    gbase_i,
  input  logic [TLM_W-1:0] glim_i,
  input  logic [AW-1:0]    lbase_i,
  input  logic [TLM_W-1:0] llim_i,
  output logic             in_range_o,
  output logic [AW-1:0]    desc_addr_o,
  output logic [1:0]       rpl_o
);
  localparam int unsigned IDX_W = SEL_W - 3;

  logic [IDX_W-1:0] idx;
  logic             local_tab;
  logic [TLM_W-1:0] tlim;
  logic [AW-1:0]    tbase;
  logic [SEL_W-1:0] last_byte;

  assign idx       = sel_i[SEL_W-1:3];
  assign local_tab = sel_i[2];
  assign rpl_o     = sel_i[1:0];
  assign tlim      = local_tab ? llim_i : glim_i;
  assign tbase     = local_tab ? lbase_i : gbase_i;
  assign last_byte = {idx, 3'b111};
  assign in_range_o  = last_byte <= tlim;
  assign desc_addr_o = tbase + {{(AW-SEL_W){1'b0}}, idx, 3'b000};
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_pkg::*;
(
  input  logic [31:0]   lo_i,
  input  logic [31:0]   hi_i,
  input  logic          is_stack_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] lim_o,
  output attr_t         attr_o,
  output cause_e        cause_o
);
  logic [19:0] lim20;
  logic        stack_ok;

  assign base_o = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
  assign lim20  = {hi_i[19:16], lo_i[15:0]};
  assign lim_o  = hi_i[23] ? {lim20, 12'hfff} : {12'h000, lim20};

  assign attr_o.g   = hi_i[23];
  assign attr_o.db  = hi_i[22];
  assign attr_o.lng = hi_i[21];
  assign attr_o.avl = hi_i[20];
  assign attr_o.p   = hi_i[15];
  assign attr_o.dpl = hi_i[14:13];
  assign attr_o.s   = hi_i[12];
  assign attr_o.typ = hi_i[11:8];

  // writable data segment: S set, not code, write bit set
  assign stack_ok = hi_i[12] & ~hi_i[11] & hi_i[9];

  always_comb begin
    if (is_stack_i && !stack_ok) cause_o = CAUSE_GP;
    else if (!hi_i[15])          cause_o = CAUSE_NP;
    else                         cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  cache_t           wr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output cache_t           rd_o
);
  cache_t [NUM_SEG-1:0] ent;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    cache_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g))        q <= wr_i;
    end
    assign ent[g] = q;
  end

  always_comb begin
    rd_o = '0;
    for (int k = 0; k < NUM_SEG; k++)
      if (rd_idx_i == IDX_W'(k)) rd_o = ent[k];
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          bad_reg_i,
  input  cache_t        ent_i,
  input  logic [AW-1:0] off_i,
  output logic          valid_o,
  output logic          fault_o,
  output logic [1:0]    cause_o,
  output logic [AW-1:0] lin_o,
  output logic [11:0]   attr_o,
  output logic [1:0]    rpl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= CAUSE_NONE;
      lin_o   <= '0;
      attr_o  <= '0;
      rpl_o   <= '0;
    end else begin
      valid_o <= req_i;
      fault_o <= 1'b0;
      cause_o <= CAUSE_NONE;
      lin_o   <= '0;
      attr_o  <= '0;
      rpl_o   <= '0;
      if (req_i) begin
        if (bad_reg_i) begin
          fault_o <= 1'b1;
          cause_o <= CAUSE_REG;
        end else if (!ent_i.vld) begin
          fault_o <= 1'b1;
          cause_o <= CAUSE_NP;
        end else if (off_i > ent_i.lim) begin
          fault_o <= 1'b1;
          cause_o <= CAUSE_GP;
        end else begin
          lin_o  <= ent_i.base + off_i;
          attr_o <= ent_i.attr;
          rpl_o  <= ent_i.rpl;
        end
      end
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG   = 6,
  parameter int unsigned STACK_IDX = 2,
  localparam int unsigned SREG_W   = $clog2(NUM_SEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     gtab_base_i,
  input  logic [TLM_W-1:0]  gtab_lim_i,
  input  logic [AW-1:0]     ltab_base_i,
  input  logic [TLM_W-1:0]  ltab_lim_i,
  input  logic              ld_req_i,
  input  logic [SREG_W-1:0] ld_sreg_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  output logic              busy_o,
  output logic              ld_done_o,
  output logic              ld_fault_o,
  output logic [1:0]        ld_cause_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              xl_req_i,
  input  logic [SREG_W-1:0] xl_sreg_i,
  input  logic [AW-1:0]     xl_off_i,
  output logic              xl_valid_o,
  output logic              xl_fault_o,
  output logic [1:0]        xl_cause_o,
  output logic [AW-1:0]     lin_addr_o,
  output logic [11:0]       xl_attr_o,
  output logic [1:0]        xl_rpl_o
);
  localparam logic [SREG_W:0] NSEG_L = (SREG_W+1)'(NUM_SEG);

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_e;

  st_e               state;
  logic [AW-1:0]     addr_q;
  logic [31:0]       lo_q;
  logic [SREG_W-1:0] pend_sreg;
  logic [1:0]        pend_rpl;

  logic              sel_in_range;
  logic [AW-1:0]     sel_addr;
  logic [1:0]        sel_rpl;
  logic [AW-1:0]     dec_base;
  logic [AW-1:0]     dec_lim;
  attr_t             dec_attr;
  cause_e            dec_cause;
  logic              ld_bad_reg;
  logic              xl_bad_reg;
  logic              last_beat;
  logic              cache_we;
  cache_t            cache_wr;
  cache_t            cache_rd;

  assign ld_bad_reg = {1'b0, ld_sreg_i} >= NSEG_L;
  assign xl_bad_reg = {1'b0, xl_sreg_i} >= NSEG_L;

  seg_sel_decode u_sel (
    .sel_i       (ld_sel_i),
    .gbase_i     (gtab_base_i),
    .glim_i      (gtab_lim_i),
    .lbase_i     (ltab_base_i),
    .llim_i      (ltab_lim_i),
    .in_range_o  (sel_in_range),
    .desc_addr_o (sel_addr),
    .rpl_o       (sel_rpl)
  );

  seg_desc_decode u_dec (
    .lo_i       (lo_q),
    .hi_i       (mem_rdata_i),
    .is_stack_i (pend_sreg == SREG_W'(STACK_IDX)),
    .base_o     (dec_base),
    .lim_o      (dec_lim),
    .attr_o     (dec_attr),
    .cause_o    (dec_cause)
  );

  assign last_beat = (state == ST_HI) && mem_rvalid_i;
  assign cache_we  = last_beat && (dec_cause == CAUSE_NONE);
  assign cache_wr  = '{vld: 1'b1, base: dec_base, lim: dec_lim, attr: dec_attr, rpl: pend_rpl};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      lo_q       <= '0;
      pend_sreg  <= '0;
      pend_rpl   <= '0;
      ld_done_o  <= 1'b0;
      ld_fault_o <= 1'b0;
      ld_cause_o <= CAUSE_NONE;
    end else begin
      ld_done_o  <= 1'b0;
      ld_fault_o <= 1'b0;
      ld_cause_o <= CAUSE_NONE;
      unique case (state)
        ST_IDLE: if (ld_req_i) begin
          if (ld_bad_reg) begin
            ld_fault_o <= 1'b1;
            ld_cause_o <= CAUSE_REG;
          end else if (!sel_in_range) begin
            ld_fault_o <= 1'b1;
            ld_cause_o <= CAUSE_GP;
          end else begin
            state     <= ST_LO;
            addr_q    <= sel_addr;
            pend_sreg <= ld_sreg_i;
            pend_rpl  <= sel_rpl;
          end
        end
        ST_LO: if (mem_rvalid_i) begin
          lo_q   <= mem_rdata_i;
          addr_q <= addr_q + AW'(4);
          state  <= ST_HI;
        end
        ST_HI: if (mem_rvalid_i) begin
          state <= ST_IDLE;
          if (dec_cause == CAUSE_NONE) ld_done_o <= 1'b1;
          else begin
            ld_fault_o <= 1'b1;
            ld_cause_o <= dec_cause;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = state != ST_IDLE;
  assign mem_req_o  = state != ST_IDLE;
  assign mem_addr_o = addr_q;

  seg_cache #(.NUM_SEG(NUM_SEG), .IDX_W(SREG_W)) u_cache (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cache_we),
    .wr_idx_i (pend_sreg),
    .wr_i     (cache_wr),
    .rd_idx_i (xl_sreg_i),
    .rd_o     (cache_rd)
  );

  seg_xlate u_xl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (xl_req_i),
    .bad_reg_i (xl_bad_reg),
    .ent_i     (cache_rd),
    .off_i     (xl_off_i),
    .valid_o   (xl_valid_o),
    .fault_o   (xl_fault_o),
    .cause_o   (xl_cause_o),
    .lin_o     (lin_addr_o),
    .attr_o    (xl_attr_o),
    .rpl_o     (xl_rpl_o)
  );
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] gtab_base_i,
  input logic [15:0] gtab_lim_i,
  input logic [31:0] ltab_base_i,
  input logic [15:0] ltab_lim_i,
  input logic        ld_req_i,
  input logic [2:0]  ld_sreg_i,
  input logic [15:0] ld_sel_i,
  input logic        busy_o,
  input logic        ld_done_o,
  input logic        ld_fault_o,
  input logic [1:0]  ld_cause_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic [31:0] mem_rdata_i,
  input logic        xl_req_i,
  input logic [2:0]  xl_sreg_i,
  input logic [31:0] xl_off_i,
  input logic        xl_valid_o,
  input logic        xl_fault_o,
  input logic [1:0]  xl_cause_o,
  input logic [31:0] lin_addr_o,
  input logic [11:0] xl_attr_o,
  input logic [1:0]  xl_rpl_o
);
  // R4
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  // R9
  done_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_done_o |-> !ld_fault_o && ld_cause_o == 2'b00);

  // R9
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fault_o |-> ld_cause_o != 2'b00);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_done_o |-> !busy_o);

  // R10
  start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !ld_done_o && !ld_fault_o);

  // R11
  xl_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_req_i |=> xl_valid_o);

  // R11
  xl_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xl_req_i |=> !xl_valid_o && lin_addr_o == 32'h0);

  // R12
  xl_fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_o && xl_fault_o |-> lin_addr_o == 32'h0 && xl_cause_o != 2'b00);
endmodule

bind seg_xlate_unit seg_xlate_unit_chk u_chk (.*);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
  localparam logic [31:0] GB = 32'h100, LB = 32'h300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic        ld_req = 1'b0, xl_req = 1'b0, mem_rvalid = 1'b0;
  logic [2:0]  ld_sreg = '0, xl_sreg = '0;
  logic [15:0] ld_sel = '0;
  logic [31:0] xl_off = '0, mem_rdata = '0;
  logic        busy_o, ld_done_o, ld_fault_o, mem_req_o, xl_valid_o, xl_fault_o;
  logic [1:0]  ld_cause_o, xl_cause_o, xl_rpl_o;
  logic [31:0] mem_addr_o, lin_addr_o;
  logic [11:0] xl_attr_o;

  int vectors = 0, fails = 0;
  string cur_tag = "R1";
  logic [31:0] mem [256];
  int lat = 0, wcnt = 0;
  bit rand_lat = 0;

  always #5 clk = ~clk;

  seg_xlate_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .gtab_base_i(GB), .gtab_lim_i(16'h003f), .ltab_base_i(LB), .ltab_lim_i(16'h001f),
    .ld_req_i(ld_req), .ld_sreg_i(ld_sreg), .ld_sel_i(ld_sel),
    .busy_o(busy_o), .ld_done_o(ld_done_o), .ld_fault_o(ld_fault_o), .ld_cause_o(ld_cause_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .xl_req_i(xl_req), .xl_sreg_i(xl_sreg), .xl_off_i(xl_off),
    .xl_valid_o(xl_valid_o), .xl_fault_o(xl_fault_o), .xl_cause_o(xl_cause_o),
    .lin_addr_o(lin_addr_o), .xl_attr_o(xl_attr_o), .xl_rpl_o(xl_rpl_o));

  // memory: answers a held request after lat idle cycles
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[mem_addr_o[9:2]];
        if (rand_lat) lat = $urandom % 3;
      end else wcnt++;
    end
  end

  function automatic logic [63:0] mk_desc(logic [31:0] b, logic [19:0] l, logic g, logic avl,
                                          logic [1:0] dpl, logic s, logic [3:0] t, logic p);
    logic [31:0] lo, hi;
    lo = {b[15:0], l[15:0]};
    hi = {b[31:24], g, 1'b1, 1'b0, avl, l[19:16], p, dpl, s, t, b[23:16]};
    return {hi, lo};
  endfunction

  task automatic put(int wbase, int idx, logic [63:0] d);
    mem[wbase + 2*idx]     = d[31:0];
    mem[wbase + 2*idx + 1] = d[63:32];
  endtask

  task automatic cmp(string fld, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur_tag, fld, act, exp, $time);
    end
  endtask

  // reference model, expected outputs for the cycle after each edge
  int ph = 0, m_sreg = 0;
  logic [31:0] m_addr, m_lo, hi, nb, nl;
  logic [19:0] l20;
  logic [1:0]  m_rpl;
  logic        c_vld [6];
  logic [31:0] c_base [6], c_lim [6];
  logic [11:0] c_attr [6];
  logic [1:0]  c_rpl [6];
  logic        e_busy, e_done, e_fault, e_xv, e_xf;
  logic [1:0]  e_cause, e_xc, e_rpl;
  logic [31:0] e_addr, e_lin;
  logic [11:0] e_attr;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; e_busy = 0; e_done = 0; e_fault = 0; e_cause = 0; e_addr = 0;
      e_xv = 0; e_xf = 0; e_xc = 0; e_lin = 0; e_attr = 0; e_rpl = 0;
      for (int k = 0; k < 6; k++) c_vld[k] = 0;
    end else begin
      vectors++;
      cmp("busy", 32'(busy_o), 32'(e_busy));
      cmp("mem_req", 32'(mem_req_o), 32'(e_busy));
      if (e_busy) cmp("mem_addr", mem_addr_o, e_addr);
      cmp("ld_done", 32'(ld_done_o), 32'(e_done));
      cmp("ld_fault", 32'(ld_fault_o), 32'(e_fault));
      cmp("ld_cause", 32'(ld_cause_o), 32'(e_cause));
      cmp("xl_valid", 32'(xl_valid_o), 32'(e_xv));
      cmp("xl_fault", 32'(xl_fault_o), 32'(e_xf));
      cmp("xl_cause", 32'(xl_cause_o), 32'(e_xc));
      cmp("lin_addr", lin_addr_o, e_lin);
      cmp("xl_attr", 32'(xl_attr_o), 32'(e_attr));
      cmp("xl_rpl", 32'(xl_rpl_o), 32'(e_rpl));

      e_xv = xl_req; e_xf = 0; e_xc = 0; e_lin = 0; e_attr = 0; e_rpl = 0;
      if (xl_req) begin
        if (xl_sreg > 5)              begin e_xf = 1; e_xc = 2'b11; end
        else if (!c_vld[xl_sreg])     begin e_xf = 1; e_xc = 2'b10; end
        else if (xl_off > c_lim[xl_sreg]) begin e_xf = 1; e_xc = 2'b01; end
        else begin
          e_lin  = c_base[xl_sreg] + xl_off;
          e_attr = c_attr[xl_sreg];
          e_rpl  = c_rpl[xl_sreg];
        end
      end

      e_done = 0; e_fault = 0; e_cause = 0;
      if (ph == 0) begin
        if (ld_req) begin
          if (ld_sreg > 5) begin e_fault = 1; e_cause = 2'b11; end
          else if (int'(ld_sel[15:3]) * 8 + 7 > (ld_sel[2] ? 32'h1f : 32'h3f)) begin
            e_fault = 1; e_cause = 2'b01;
          end else begin
            ph = 1; m_sreg = int'(ld_sreg); m_rpl = ld_sel[1:0];
            m_addr = (ld_sel[2] ? LB : GB) + 32'(ld_sel[15:3]) * 8;
          end
        end
      end else if (ph == 1) begin
        if (mem_rvalid) begin m_lo = mem_rdata; ph = 2; end
      end else if (mem_rvalid) begin
        ph = 0;
        hi  = mem_rdata;
        nb  = {hi[31:24], hi[7:0], m_lo[31:16]};
        l20 = {hi[19:16], m_lo[15:0]};
        nl  = hi[23] ? ({12'h0, l20} << 12) | 32'hfff : {12'h0, l20};
        if (m_sreg == 2 && !(hi[12] && !hi[11] && hi[9])) begin e_fault = 1; e_cause = 2'b01; end
        else if (!hi[15]) begin e_fault = 1; e_cause = 2'b10; end
        else begin
          e_done = 1;
          c_vld[m_sreg] = 1; c_base[m_sreg] = nb; c_lim[m_sreg] = nl; c_rpl[m_sreg] = m_rpl;
          c_attr[m_sreg] = {hi[23], hi[22], hi[21], hi[20], hi[15], hi[14:13], hi[12], hi[11:8]};
        end
      end
      e_busy = ph != 0;
      e_addr = (ph == 2) ? m_addr + 4 : m_addr;
    end
  end

  task automatic load(int s, logic [15:0] sel);
    int n;
    @(negedge clk); ld_req = 1; ld_sreg = 3'(s); ld_sel = sel;
    @(negedge clk); ld_req = 0;
    n = 0;
    while (busy_o && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic xl(int s, logic [31:0] off);
    @(negedge clk); xl_req = 1; xl_sreg = 3'(s); xl_off = off;
    @(negedge clk); xl_req = 0;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    put(64, 0, mk_desc(32'h1000_0000, 20'h0ffff, 0, 1, 2'd0, 1, 4'b0010, 1));
    put(64, 1, mk_desc(32'h0000_0000, 20'hfffff, 1, 0, 2'd0, 1, 4'b1010, 1));
    put(64, 2, mk_desc(32'h0000_2000, 20'h00010, 0, 0, 2'd3, 1, 4'b0000, 1));
    put(64, 3, mk_desc(32'h0000_3000, 20'h00fff, 0, 0, 2'd0, 1, 4'b0010, 0));
    put(64, 4, mk_desc(32'h8000_0000, 20'h00003, 1, 0, 2'd1, 1, 4'b0010, 1));
    put(64, 5, mk_desc(32'h0000_5000, 20'h00067, 0, 0, 2'd0, 0, 4'b1001, 1));
    put(64, 6, mk_desc(32'hffff_f000, 20'h02000, 0, 0, 2'd0, 1, 4'b0010, 1));
    put(64, 7, mk_desc(32'h0000_7000, 20'h000ff, 0, 0, 2'd0, 1, 4'b0000, 0));
    for (int k = 0; k < 4; k++)
      put(192, k, mk_desc(32'h0040_0000 + 32'(k) * 32'h1000, 20'h00fff, 0, 0, 2'd3, 1, 4'b0010, 1));

    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk(busy_o == 0 && mem_req_o == 0, "R1 busy/req in reset", {busy_o, mem_req_o}, 0);
    chk(ld_done_o == 0 && ld_fault_o == 0 && xl_valid_o == 0, "R1 pulses in reset",
        {ld_done_o, ld_fault_o, xl_valid_o}, 0);
    rst_n = 1;
    for (int s = 0; s < 6; s++) xl(s, 0);

    cur_tag = "R2"; load(3, 16'h0003); xl(3, 32'h1234);
    load(4, 16'h000d); xl(4, 32'h0fff);
    cur_tag = "R4"; lat = 2; load(0, 16'h0008); lat = 0;
    cur_tag = "R5"; xl(0, 32'h0);
    cur_tag = "R6"; xl(0, 32'hffff_ffff);
    load(5, 16'h0020); xl(5, 32'h3fff); xl(5, 32'h4000);
    cur_tag = "R12"; xl(3, 32'h0000_ffff); xl(3, 32'h0001_0000);
    cur_tag = "R11"; load(0, 16'h0030); xl(0, 32'h1800);
    cur_tag = "R3"; load(3, 16'h0040); load(3, 16'h0024); xl(3, 32'h10);
    load(1, 16'h001c); xl(1, 32'h0);
    cur_tag = "R7"; load(3, 16'h0018); xl(3, 32'h20);
    cur_tag = "R8"; load(2, 16'h0010); load(2, 16'h0008); load(2, 16'h0028);
    load(2, 16'h0038); xl(2, 32'h0);
    load(2, 16'h0000); xl(2, 32'h8);
    load(3, 16'h0038); load(1, 16'h0010); xl(1, 32'h10); xl(1, 32'h11);
    cur_tag = "R13"; load(6, 16'h0000); load(7, 16'h0000); xl(7, 32'h0); xl(6, 32'h0);

    cur_tag = "R10";
    lat = 2;
    @(negedge clk); ld_req = 1; ld_sreg = 3'd4; ld_sel = 16'h0030;
    @(negedge clk); ld_sreg = 3'd5; ld_sel = 16'h0008;
    chk(busy_o == 1, "R10 busy after accept", 32'(busy_o), 1);
    @(negedge clk); ld_req = 0;
    while (busy_o) @(negedge clk);
    lat = 0;
    xl(5, 32'h4000); xl(4, 32'h1800);

    cur_tag = "R9";
    @(negedge clk); xl_req = 1; xl_sreg = 3'd5; xl_off = 32'h100;
    ld_req = 1; ld_sreg = 3'd5; ld_sel = 16'h0004;
    @(negedge clk); ld_req = 0;
    while (busy_o) @(negedge clk);
    @(negedge clk); xl_req = 0;

    cur_tag = "R4";
    rand_lat = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      ld_req  = ($urandom % 6) == 0;
      ld_sreg = 3'($urandom % 8);
      ld_sel  = {13'($urandom % 10), 1'($urandom), 2'($urandom)};
      xl_req  = 1'($urandom);
      xl_sreg = 3'($urandom % 8);
      case ($urandom % 6)
        0: xl_off = 32'h0;
        1: xl_off = 32'hfff;
        2: xl_off = 32'h1000;
        3: xl_off = 32'hffff;
        4: xl_off = 32'h3fff;
        default: xl_off = $urandom;
      endcase
    end
    @(negedge clk); ld_req = 0; xl_req = 0;
    while (busy_o) @(negedge clk);
    finish_run();
  end
endmodule